// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks lock reservations that load-linked / store-conditional sequences from several requesters place on cache lines. The memory pipeline presents each completed access to the monitor as a one-cycle strobe. The strobe carries the line address, the access kind and the id of the requester. One cycle later the monitor returns a success flag and a one-bit result value, which the core writes back as the store-conditional outcome. The monitor does not move data and takes no part in coherence. It only keeps the reservation table consistent with the stream of completions.

Reservations sit in a small table of `NENT` entries. Each entry holds a line address and an owner id. A load-linked to a line that is not yet reserved takes a free entry. When no entry is free it evicts the reservation that was allocated longest ago. A store-conditional wins only when its own id holds the line. Any store-conditional, winning or losing, removes the reservation, and so does any plain store to a reserved line.

The access kind is a 2-bit code: 0 = read, 1 = store, 2 = load-linked, 3 = store-conditional.

Top module: `resv_monitor`

## Requirements
- R1: After reset no line is reserved and `res_valid` is 0, so a store-conditional (kind 3) issued first fails, with `res_ok`=0 and `res_value`=0.
- R2: A load-linked (kind 2) completion reserves its line for its requester id and reports `res_ok`=1, `res_value`=0.
- R3: A store-conditional (kind 3) reports `res_ok`=1 and `res_value`=1 only if its line is reserved by the same requester id. Otherwise it reports `res_ok`=0 and `res_value`=0.
- R4: Every store-conditional (kind 3) removes the reservation on its line, whether it succeeds or fails. A second store-conditional to that line then fails.
- R5: A store (kind 1) to a reserved line removes that reservation, whoever owns it. A store leaves reservations on other lines intact and reports `res_ok`=1, `res_value`=0.
- R6: A read (kind 0) changes no reservation and reports `res_ok`=1, `res_value`=0.
- R7: A load-linked (kind 2) to a line that is already reserved hands ownership to the new requester without taking another entry. It does not change that entry's allocation age.
- R8: The table holds `NENT` reservations. A load-linked (kind 2) to a new line while all entries are in use replaces the entry allocated earliest among those present.
- R9: `res_valid` is 1 in exactly the cycle after a cycle with `cmp_valid`=1, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion strobe, one cycle per completed access |
| cmp_line | input | AW | Line address of the completed access |
| cmp_kind | input | 2 | Access kind: 0 read, 1 store, 2 load-linked, 3 store-conditional |
| cmp_id | input | IW | Requester id |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_ok | output | 1 | Success flag of the completed access |
| res_value | output | 1 | Store-conditional result value returned to the core |

## Verification
The hardest state to reach from the ports is a full table with allocation ages that are no longer in entry order. To get there, reservations must be freed in the middle of the age order and then refilled. Only then does the choice of the oldest entry differ from a plain rotating pointer. The bench reaches this state in two ways. A directed sequence fills the table, frees a middle entry with a store-conditional, refills it, and then forces an eviction. A long pseudo-random stream of all four kinds over eight lines and four ids keeps the table near full while stores and store-conditionals free entries at arbitrary ages. The bench compares every result against an arithmetic model that records the allocation order.

// File: rtl/resv_pkg.sv
package resv_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_LL    = 2'd2,
      KIND_SC    = 2'd3
   } cmp_kind_t;

endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
   parameter int AW   = 26,
   parameter int IW   = 6,
   parameter int NENT = 4,
   parameter int RW   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] look_line,
   input  logic          alloc,
   input  logic          set_own,
   input  logic          clear,
   input  logic          age_up,
   input  logic          age_dn,
   input  logic [AW-1:0] new_line,
   input  logic [IW-1:0] new_id,
   output logic          vld,
   output logic [AW-1:0] line,
   output logic [IW-1:0] owner,
   output logic [RW-1:0] rank,
   output logic          hit
);

   assign hit = vld && (line == look_line);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld   <= 1'b0;
         line  <= '0;
         owner <= '0;
         rank  <= '0;
      end else if (alloc) begin
         vld   <= 1'b1;
         line  <= new_line;
         owner <= new_id;
         rank  <= '0;
      end else begin
         if (clear)   vld   <= 1'b0;
         if (set_own) owner <= new_id;
         if (age_up)  rank  <= rank + 1'b1;
         if (age_dn)  rank  <= rank - 1'b1;
      end
   end

   AST_AGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(age_up && age_dn));                                          // R8
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && age_up) |-> (32'(rank) < NENT - 1));                   // R8
   AST_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && age_dn) |-> (rank != '0));                             // R8
   AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !vld || (32'(rank) == NENT - 1));                    // R8

endmodule

// File: rtl/resv_pick.sv
module resv_pick #(
   parameter int NENT = 4,
   parameter int RW   = 2
) (
   input  logic [NENT-1:0] vld,
   input  logic [RW-1:0]   rank [NENT],
   output logic [NENT-1:0] sel
);

   logic [NENT-1:0] free_sel;
   logic [NENT-1:0] old_sel;

   always_comb begin
      logic found;
      found    = 1'b0;
      free_sel = '0;
      for (int i = 0; i < NENT; i++) begin
         if (!vld[i] && !found) begin
            free_sel[i] = 1'b1;
            found       = 1'b1;
         end
      end
   end

   for (genvar g = 0; g < NENT; g++) begin : g_old
      assign old_sel[g] = (32'(rank[g]) == NENT - 1);
   end

   assign sel = (&vld) ? old_sel : free_sel;

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
   parameter int AW   = 26,
   parameter int IW   = 6,
   parameter int NENT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmp_valid,
   input  logic [AW-1:0] cmp_line,
   input  logic [1:0]    cmp_kind,
   input  logic [IW-1:0] cmp_id,
   output logic          res_valid,
   output logic          res_ok,
   output logic          res_value
);
   import resv_pkg::*;

   localparam int RW = (NENT > 1) ? $clog2(NENT) : 1;

   if (NENT < 2) begin : g_chk_nent
      $error("resv_monitor: NENT must be at least 2");
   end
   if (AW < 1 || IW < 1) begin : g_chk_width
      $error("resv_monitor: AW and IW must be positive");
   end

   logic [NENT-1:0] vld_v, hit_v, alloc_v, own_v, clr_v, up_v, dn_v, pick_v;
   logic [AW-1:0]   line_a  [NENT];
   logic [IW-1:0]   owner_a [NENT];
   logic [RW-1:0]   rank_a  [NENT];

   logic          is_ll, is_sc, is_st, any_hit, do_alloc, sc_win, clr_any;
   logic [IW-1:0] hit_owner;
   logic [RW-1:0] clr_rank;

   assign is_ll = cmp_valid && (cmp_kind_t'(cmp_kind) == KIND_LL);
   assign is_sc = cmp_valid && (cmp_kind_t'(cmp_kind) == KIND_SC);
   assign is_st = cmp_valid && (cmp_kind_t'(cmp_kind) == KIND_STORE);

   assign any_hit  = |hit_v;
   assign do_alloc = is_ll && !any_hit;
   assign clr_any  = (is_sc || is_st) && any_hit;

   always_comb begin
      hit_owner = '0;
      clr_rank  = '0;
      for (int i = 0; i < NENT; i++) begin
         hit_owner = hit_owner | (owner_a[i] & {IW{hit_v[i]}});
         clr_rank  = clr_rank  | (rank_a[i]  & {RW{hit_v[i]}});
      end
   end

   assign sc_win = is_sc && any_hit && (hit_owner == cmp_id);

   resv_pick #(.NENT(NENT), .RW(RW)) u_pick (
      .vld  (vld_v),
      .rank (rank_a),
      .sel  (pick_v)
   );

   for (genvar g = 0; g < NENT; g++) begin : g_slot
      assign alloc_v[g] = do_alloc && pick_v[g];
      assign own_v[g]   = is_ll && hit_v[g];
      assign clr_v[g]   = (is_sc || is_st) && hit_v[g];
      assign up_v[g]    = do_alloc && !pick_v[g] && vld_v[g];
      assign dn_v[g]    = clr_any && vld_v[g] && (rank_a[g] > clr_rank);

      resv_slot #(.AW(AW), .IW(IW), .NENT(NENT), .RW(RW)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .look_line (cmp_line),
         .alloc     (alloc_v[g]),
         .set_own   (own_v[g]),
         .clear     (clr_v[g]),
         .age_up    (up_v[g]),
         .age_dn    (dn_v[g]),
         .new_line  (cmp_line),
         .new_id    (cmp_id),
         .vld       (vld_v[g]),
         .line      (line_a[g]),
         .owner     (owner_a[g]),
         .rank      (rank_a[g]),
         .hit       (hit_v[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_ok    <= 1'b0;
         res_value <= 1'b0;
      end else begin
         res_valid <= cmp_valid;
         res_ok    <= cmp_valid && (!(cmp_kind_t'(cmp_kind) == KIND_SC) || sc_win);
         res_value <= sc_win;
      end
   end

   function automatic logic held(input logic [AW-1:0] a, input logic [NENT-1:0] v,
                                 input logic [AW-1:0] l [NENT]);
      logic r;
      r = 1'b0;
      for (int i = 0; i < NENT; i++) r = r | (v[i] && (l[i] == a));
      return r;
   endfunction

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_v));                                              // R7
   AST_LL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      is_ll |=> held($past(cmp_line), vld_v, line_a));               // R2
   AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      is_sc |=> !held($past(cmp_line), vld_v, line_a));              // R4
   AST_ST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      is_st |=> !held($past(cmp_line), vld_v, line_a));              // R5
   AST_VALUE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      res_value |-> (res_ok && res_valid));                          // R3
   AST_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |=> res_valid);                                      // R9
   AST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> !res_valid);                                    // R9
   AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      do_alloc |-> ($countones(pick_v) == 1));                       // R8

endmodule

// File: tb/resv_monitor_test.sv
`timescale 1ns/1ps
module resv_monitor_test;
   localparam int AW = 3;
   localparam int IW = 2;
   localparam int NENT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_valid = 1'b0;
   logic [AW-1:0] cmp_line = '0;
   logic [1:0] cmp_kind = '0;
   logic [IW-1:0] cmp_id = '0;
   logic res_valid, res_ok, res_value;

   int n_chk = 0;
   int n_bad = 0;

   // reference table
   bit      m_v   [NENT];
   int      m_line[NENT];
   int      m_own [NENT];
   int      m_seq [NENT];
   int      seq_ctr = 0;

   always #4 clk = ~clk;

   resv_monitor #(.AW(AW), .IW(IW), .NENT(NENT)) uut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_line(cmp_line),
      .cmp_kind(cmp_kind), .cmp_id(cmp_id), .res_valid(res_valid),
      .res_ok(res_ok), .res_value(res_value)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NENT; i++) m_v[i] = 0;
   endtask

   // returns {ok, value}
   function automatic int model_op(input int k, input int a, input int id);
      int h, slot, best;
      h = -1;
      for (int i = 0; i < NENT; i++) if (m_v[i] && m_line[i] == a) h = i;
      case (k)
         2: begin
            if (h >= 0) m_own[h] = id;
            else begin
               slot = -1;
               for (int i = NENT - 1; i >= 0; i--) if (!m_v[i]) slot = i;
               if (slot < 0) begin
                  best = 0;
                  for (int i = 1; i < NENT; i++) if (m_seq[i] < m_seq[best]) best = i;
                  slot = best;
               end
               m_v[slot] = 1; m_line[slot] = a; m_own[slot] = id;
               m_seq[slot] = seq_ctr; seq_ctr++;
            end
            return 2;
         end
         3: begin
            if (h >= 0) begin
               m_v[h] = 0;
               if (m_own[h] == id) return 3;
            end
            return 0;
         end
         1: begin
            if (h >= 0) m_v[h] = 0;
            return 2;
         end
         default: return 2;
      endcase
   endfunction

   task automatic op(input int k, input int a, input int id, input string tag);
      int e;
      e = model_op(k, a, id);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_kind = 2'(k); cmp_line = AW'(a); cmp_id = IW'(id);
      @(negedge clk);
      cmp_valid = 1'b0;
      check({tag, " R9 valid"}, int'(res_valid), 1);
      check({tag, " ok/value"}, int'({res_ok, res_value}), e);
   endtask

   task automatic idle_check();
      @(negedge clk);
      check("R9 idle res_valid", int'(res_valid), 0);
   endtask

   initial begin
      #(8 * 190000);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      model_clear();
      repeat (3) @(negedge clk);
      check("R1 reset res_valid", int'(res_valid), 0);
      rst_n = 1'b1;
      idle_check();
      op(3, 1, 0, "R1 sc after reset");

      // R2, R3, R4 sweep over lines and id pairs
      for (int ln = 0; ln < 8; ln++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
               op(2, ln, a, "R2 ll");
               op(3, ln, b, "R3 sc");
               op(3, ln, a, "R4 second sc");
            end
      idle_check();

      // R5: store by another id breaks reservation, other lines kept
      op(2, 2, 0, "R5 ll a"); op(2, 3, 1, "R5 ll b");
      op(1, 2, 3, "R5 store");
      op(3, 2, 0, "R5 sc broken");
      op(3, 3, 1, "R5 sc kept");
      op(1, 6, 2, "R5 store unreserved");

      // R6: read has no effect
      op(2, 4, 2, "R6 ll"); op(0, 4, 1, "R6 read");
      op(3, 4, 2, "R6 sc survives read");

      // R7: owner handover
      op(2, 5, 0, "R7 ll0"); op(2, 5, 1, "R7 ll1");
      op(3, 5, 0, "R7 sc old owner");
      op(2, 5, 0, "R7 ll0 again"); op(2, 5, 3, "R7 ll3");
      op(3, 5, 3, "R7 sc new owner");

      // R8: eviction with reordered ages
      for (int ln = 0; ln < 4; ln++) op(2, ln, ln, "R8 fill");
      op(2, 0, 2, "R8 relock no refresh");
      op(3, 1, 1, "R8 free middle");
      op(2, 6, 1, "R8 refill");
      op(2, 7, 0, "R8 evict oldest");
      op(3, 0, 2, "R8 sc evicted");
      op(3, 2, 2, "R8 sc kept");
      op(3, 6, 1, "R8 sc refilled");
      op(3, 7, 0, "R8 sc new");
      idle_check();

      // random mix against the reference model
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         op(int'(lfsr[1:0]), int'(lfsr[6:4]), int'(lfsr[9:8]), "R3 R8 random");
      end
      idle_check();

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule